// File: doc/BRIEF.md
# Multi-Level Column Data Sequencer

This block feeds the switch side of a serial charge-sharing column converter in a display driver. It takes an 8-bit pixel word, holds it, and then steps through a short run of charging cycles. In each cycle it places a one-hot code on a set of switch-select lines, and that code picks one of several reference column voltages. With more reference levels, each cycle carries more data bits, so a conversion needs fewer charging cycles.

Three level counts are supported: two levels (one bit per cycle, eight cycles), four levels (two bits per cycle, four cycles) and sixteen levels (four bits per cycle, two cycles). The bits are interleaved across the word. In every cycle the code is built from bits that lie a fixed stride apart, the stride being the cycle count. The lowest bit positions are used first.

The host pulses `start` with a word and a mode, then pulses `strobe` once per charging period. `done` reports that the run is over and stays high until the next word is accepted.

Top module: `mlvl_col_seq`

## Requirements
- R1: After reset, `col_sel` is all zeros and `done` is low.
- R2: A `start` pulse is accepted only while no conversion is running, that is while idle or while `done` is high. On acceptance, `pixel_in` and `mode` are captured. From the next cycle `done` is low and `col_sel` shows charging cycle 0.
- R3: Mode encoding: 0 selects two levels (8 cycles), 1 selects four levels (4 cycles), and 2 or 3 select sixteen levels (2 cycles). Only the low 2, 4 or 16 select lines can be driven, according to the mode.
- R4: In charging cycle k, with N cycles per conversion, bit j of the level code equals word bit k + j*N, and bit j=0 is the least significant. In four-level mode this gives the code {B[k+4], B[k]}. `col_sel` equals 1 shifted left by the code, so exactly one line is high while running.
- R5: Each `strobe` while running advances the conversion by exactly one cycle. A `strobe` while idle or done has no effect.
- R6: A `strobe` in the last charging cycle makes `done` rise and `col_sel` go to zero on the following cycle. Both then hold until a new start is accepted.
- R7: While a conversion runs, `start` is ignored, and changes on `pixel_in` or `mode` have no effect on `col_sel`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Load strobe for a new pixel word |
| pixel_in | input | 8 | Pixel word to convert |
| mode | input | 2 | Level count select (0: 2, 1: 4, 2 or 3: 16) |
| strobe | input | 1 | Charging-period advance pulse |
| col_sel | output | 16 | One-hot reference voltage select, zero when not running |
| done | output | 1 | Conversion finished, held until the next accepted start |

## Verification
Two events can arrive in the same cycle: a `start` request and the `strobe` that closes the last charging cycle. A second collision is `start` and `strobe` together while idle or done. The bench provokes both by raising `start` at random on every cycle of a run, including the closing strobe, while it also scrambles `pixel_in` and `mode`. The closing strobe must win: `done` rises and the request is dropped. A start from idle or done must win over a simultaneous strobe and show cycle 0 of the new word. These outcomes are judged against codes that a bench function derives from the stride rule.

// File: rtl/mlvl_col_seq.sv
module mlvl_col_seq #(
  parameter int unsigned PIX_W = 8
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 start,
  input  logic [PIX_W-1:0]     pixel_in,
  input  logic [1:0]           mode,
  input  logic                 strobe,
  output logic [15:0]          col_sel,
  output logic                 done
);
  localparam int unsigned CNT_W = $clog2(PIX_W);

  typedef enum logic [1:0] {S_IDLE, S_RUN, S_DONE} st_t;

  st_t              st_q;
  logic [PIX_W-1:0] word_q;
  logic [1:0]       lvl_q;
  logic [CNT_W-1:0] cyc_q;
  logic [CNT_W-1:0] last_cyc;
  logic [PIX_W-1:0] sh;
  logic [3:0]       code;
  logic             accept;

  assign accept = start && (st_q != S_RUN);
  assign sh     = word_q >> cyc_q;

  always_comb begin
    case (lvl_q)
      2'd0:    last_cyc = CNT_W'(PIX_W - 1);
      2'd1:    last_cyc = CNT_W'(PIX_W / 2 - 1);
      default: last_cyc = CNT_W'(PIX_W / 4 - 1);
    endcase
  end

  always_comb begin
    case (lvl_q)
      2'd0:    code = {3'b000, sh[0]};
      2'd1:    code = {2'b00, sh[4], sh[0]};
      default: code = {sh[6], sh[4], sh[2], sh[0]};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      word_q <= '0;
      lvl_q  <= 2'd0;
      cyc_q  <= '0;
    end else if (accept) begin
      st_q   <= S_RUN;
      word_q <= pixel_in;
      lvl_q  <= (mode == 2'd3) ? 2'd2 : mode;
      cyc_q  <= '0;
    end else if (st_q == S_RUN && strobe) begin
      if (cyc_q == last_cyc) st_q <= S_DONE;
      else                   cyc_q <= cyc_q + 1'b1;
    end
  end

  assign col_sel = (st_q == S_RUN) ? (16'd1 << code) : 16'd0;
  assign done    = (st_q == S_DONE);
endmodule

// File: rtl/mlvl_col_seq_chk.sv
module mlvl_col_seq_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        start,
  input logic        strobe,
  input logic [15:0] col_sel,
  input logic        done,
  input logic        running,
  input logic [7:0]  word_q,
  input logic [1:0]  lvl_q
);
  AST_SEL_ONEHOT_RUN: assert property (@(posedge clk) disable iff (!rst_n)
    running |-> $onehot(col_sel)); // R4
  AST_SEL_ZERO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> col_sel == 16'd0); // R6
  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    done && !start |=> done); // R6
  AST_ACCEPT_START: assert property (@(posedge clk) disable iff (!rst_n)
    !running && start |=> running && !done); // R2
  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    running && !strobe |=> running && $stable(col_sel)); // R7
  AST_WORD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    running |=> !running || $stable(word_q)); // R7
  AST_TWO_LEVEL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    running && lvl_q == 2'd0 |-> col_sel[15:2] == 14'd0); // R3
  AST_FOUR_LEVEL_LINES: assert property (@(posedge clk) disable iff (!rst_n)
    running && lvl_q == 2'd1 |-> col_sel[15:4] == 12'd0); // R3
endmodule

bind mlvl_col_seq mlvl_col_seq_chk u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .start   (start),
  .strobe  (strobe),
  .col_sel (col_sel),
  .done    (done),
  .running (st_q == S_RUN),
  .word_q  (word_q),
  .lvl_q   (lvl_q)
);

// File: tb/test_mlvl_col_seq.sv
`timescale 1ns/1ps
module test_mlvl_col_seq;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        start;
  logic [7:0]  pixel_in;
  logic [1:0]  mode;
  logic        strobe;
  logic [15:0] col_sel;
  logic        done;
  int checks = 0;
  int errors = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mlvl_col_seq i_mlvl_col_seq (
    .clk(clk), .rst_n(rst_n), .start(start), .pixel_in(pixel_in),
    .mode(mode), .strobe(strobe), .col_sel(col_sel), .done(done)
  );

  function automatic int n_cycles(input logic [1:0] m);
    return (m == 2'd0) ? 8 : (m == 2'd1) ? 4 : 2;
  endfunction

  function automatic logic [15:0] exp_sel(input logic [7:0] w, input logic [1:0] m, input int k);
    int n = n_cycles(m);
    int bpl = 8 / n;
    logic [3:0] c = 4'd0;
    for (int j = 0; j < bpl; j++) c[j] = w[k + j * n];
    return 16'd1 << c;
  endfunction

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic convert(input logic [7:0] w, input logic [1:0] m, input bit noisy);
    int n = n_cycles(m);
    @(negedge clk);
    start = 1'b1; pixel_in = w; mode = m; strobe = noisy ? 1'($urandom % 2) : 1'b0;
    for (int k = 0; k < n; k++) begin
      int gaps = noisy ? int'($urandom % 3) : 0;
      for (int g = 0; g <= gaps; g++) begin
        @(negedge clk);
        chk("R4 select code", col_sel, exp_sel(w, m, k));
        chk("R2 done low while running", {15'd0, done}, 16'd0);
        start = noisy ? 1'($urandom % 2) : 1'b0;
        if (noisy) begin pixel_in = 8'($urandom); mode = 2'($urandom); end
        strobe = (g == gaps);
      end
    end
    @(negedge clk);
    chk("R6 select cleared at end", col_sel, 16'd0);
    chk("R6 done raised", {15'd0, done}, 16'd1);
    start = 1'b0; strobe = 1'b1;
    @(negedge clk);
    chk("R5 strobe ignored when done", col_sel, 16'd0);
    chk("R6 done held", {15'd0, done}, 16'd1);
    strobe = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R5 watchdog actual=hung expected=finished");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    rst_n = 1'b0; start = 1'b1; pixel_in = 8'hFF; mode = 2'd1; strobe = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 reset select", col_sel, 16'd0);
    chk("R1 reset done", {15'd0, done}, 16'd0);
    rst_n = 1'b1; start = 1'b0;
    @(negedge clk);
    chk("R5 strobe ignored when idle", col_sel, 16'd0);
    chk("R1 idle done low", {15'd0, done}, 16'd0);
    strobe = 1'b0;
    convert(8'hA5, 2'd1, 1'b0);
    convert(8'h00, 2'd0, 1'b0);
    convert(8'hFF, 2'd2, 1'b0);
    convert(8'h3C, 2'd3, 1'b0);
    convert(8'h81, 2'd0, 1'b1);
    for (int i = 0; i < 300; i++) convert(8'($urandom), 2'($urandom), 1'b1);
    finished = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule